// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block copies a span of one of two one-time-programmable fuse arrays into a byte-addressed buffer. A single request carries a start address, a byte count and an array select. The primary array is the digital-side array. For this array the sequencer first asks the system for the active power state. It then runs a timed power-switch and isolation bring-up and fetches 32-bit words over an address/ready handshake. After the last word it tears the power-switch and isolation settings down in mirror order and asks for the idle state again. The secondary array is the analog-side array. It is reached one byte at a time through a narrow indirect register port: four field writes, then a ready poll.

Every wait is counted in clock cycles derived from a clock-frequency parameter. This covers the 1 ms switch settling delays, the power-state wait, and the two ready polls, which have different limits. A strap input tells the sequencer when the switch and isolation steps are not needed on this silicon. In that case they are skipped, while the write-mask override and the burst enable still toggle. Completion is reported as a one-cycle `done` or a one-cycle `err`. Tuple decoding of the raw image is left to a consumer of the buffer.

Top module: `efuse_rd_seq`

## Requirements
- R1: A primary-array request whose address or byte count has a nonzero value in bits [1:0] is refused: `err` pulses in the cycle after the request, and neither the power request nor any fuse strobe is raised.
- R2: A request with a byte count of zero ends with a `done` pulse in the cycle after the request, without raising the power request or any fuse strobe.
- R3: Once a request is accepted, `pwr_act_req` rises. No fuse or power-switch control moves until `pwr_state` equals `ACT_CODE`. `pwr_act_req` is low again by the time `done` or `err` pulses, and `m_go`/`s_wr` are only ever issued while it is high.
- R4: If `pwr_state` does not reach `ACT_CODE` within the power wait limit, the access ends with `err` and issues no fuse strobe.
- R5: The primary bring-up goes in this order: `wmask_ovr` rises, then `psw_first` rises, then after at least one millisecond of cycles `psw_second` rises in the same cycle that `iso_en` falls, then `burst_en` rises, and only then is the first `m_go` issued.
- R6: The primary tear-down mirrors it. `iso_en` rises in the same cycle that `psw_second` falls, and this comes after the last word. At least one millisecond later `psw_first` falls. After that `wmask_ovr` and `burst_en` fall together.
- R7: With `no_sw_patch` high, `psw_first`, `psw_second` and `iso_en` never change during the access, while `wmask_ovr` and `burst_en` still toggle.
- R8: Each primary word is fetched by one `m_go` pulse carrying a 4-aligned `m_addr`. Once `m_rdy` is seen it is written as `buf_wdata = m_data` with `buf_be = 4'b1111` at the word's byte offset from the start address. Little-endian placement puts buffer byte `offset+i` in `m_data[8i+7:8i]`.
- R9: When `m_rdy` does not come within the primary poll limit (1000 ms of cycles), the access ends with `err` after the full tear-down: `iso_en` high, the switches, the mask and the burst enable low, and the power request low.
- R10: Each secondary byte is fetched with four `s_wr` writes in this fixed order: select 0 with value 8'h40, select 1 with address bits [7:0], select 2 with address bits [15:8], and select 3 with value 0. After that `s_rdy` is polled and `s_rdata` is written with `buf_be = 4'b0001` in lane [7:0] at the byte's offset.
- R11: When `s_rdy` does not come within the secondary poll limit (10 ms of cycles), the access ends with `err`.
- R12: `done` and `err` are single-cycle pulses. `busy` is high from acceptance until the pulse. A request raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, sampled while idle |
| req_addr | input | ADDR_W | First fuse byte address |
| req_size | input | SIZE_W | Byte count |
| req_sec | input | 1 | 1 selects the secondary (analog) array |
| no_sw_patch | input | 1 | Strap: 1 skips the switch/isolation steps |
| pwr_act_req | output | 1 | 1 asks for active power, 0 for idle |
| pwr_state | input | 3 | Reported system power state |
| wmask_ovr | output | 1 | Power-controller write-mask override |
| psw_first | output | 1 | First fuse power-switch stage |
| psw_second | output | 1 | Second fuse power-switch stage |
| iso_en | output | 1 | Fuse-to-core isolation, high when isolated |
| burst_en | output | 1 | Primary macro burst mode |
| m_addr | output | ADDR_W | Primary word address |
| m_go | output | 1 | Primary read strobe (clears ready) |
| m_rdy | input | 1 | Primary read ready |
| m_data | input | 32 | Primary read word |
| s_wr | output | 1 | Secondary field write strobe |
| s_sel | output | 2 | Secondary field select |
| s_wdata | output | 8 | Secondary field value |
| s_rdy | input | 1 | Secondary read ready |
| s_rdata | input | 8 | Secondary read byte |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | SIZE_W | Buffer byte offset |
| buf_wdata | output | 32 | Buffer write data |
| buf_be | output | 4 | Buffer byte lanes |
| busy | output | 1 | Access in progress |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Failed completion pulse |

## Verification
A stuck or misrouted sequencer state shows up first on the power-control pins. A step taken early or skipped moves a `wmask_ovr`, `psw_*`, `iso_en` or `burst_en` edge relative to the others, and this shows within one cycle of the step. A shortened settling wait shows as a `psw_second`/`psw_first` edge spacing below the millisecond count. A wrong address cursor or lane choice corrupts buffer bytes on the very next `buf_we`. A timer that never expires shows only as a missing `err` after the poll limit, so the hang scenarios wait out the full bounded window.

// File: rtl/efr_pkg.sv
package efr_pkg;
   typedef enum logic [4:0] {
      ST_IDLE, ST_PWR_ON,
      ST_EN_WM, ST_EN_PS, ST_EN_WAIT, ST_EN_PB, ST_EN_BURST,
      ST_M_GO, ST_M_POLL,
      ST_DIS_ISO, ST_DIS_WAIT, ST_DIS_PS, ST_DIS_WM,
      ST_S_CTRL, ST_S_LO, ST_S_HI, ST_S_MODE, ST_S_POLL,
      ST_PWR_OFF
   } efr_state_e;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_LO   = 2'd1;
   localparam logic [1:0] SEL_HI   = 2'd2;
   localparam logic [1:0] SEL_MODE = 2'd3;
   localparam logic [7:0] SEC_CTRL_VAL = 8'h40;
endpackage

// File: rtl/efr_timer.sv
module efr_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/efr_cursor.sv
module efr_cursor #(
   parameter int AW = 16,
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ld_addr,
   input  logic [SW-1:0] ld_size,
   input  logic          wide,
   input  logic          step,
   output logic [AW-1:0] cur_addr,
   output logic [SW-1:0] offset,
   output logic          last
);
   logic [SW-1:0] rem;
   logic [SW-1:0] stride;

   assign stride = wide ? SW'(4) : SW'(1);
   assign last   = (rem <= stride);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         offset   <= '0;
         rem      <= '0;
      end else if (load) begin
         cur_addr <= ld_addr;
         offset   <= '0;
         rem      <= ld_size;
      end else if (step) begin
         cur_addr <= cur_addr + AW'(stride);
         offset   <= offset + stride;
         rem      <= rem - stride;
      end
   end
endmodule

// File: rtl/efuse_rd_seq.sv
module efuse_rd_seq
   import efr_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          SIZE_W      = 16,
   parameter int          CLK_KHZ     = 100000,
   parameter int          DLY_MS      = 1,
   parameter int          PWR_TMO_MS  = 5,
   parameter int          MAIN_TMO_MS = 1000,
   parameter int          SEC_TMO_MS  = 10,
   parameter logic [2:0]  ACT_CODE    = 3'd4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_sec,
   input  logic              no_sw_patch,
   output logic              pwr_act_req,
   input  logic [2:0]        pwr_state,
   output logic              wmask_ovr,
   output logic              psw_first,
   output logic              psw_second,
   output logic              iso_en,
   output logic              burst_en,
   output logic [ADDR_W-1:0] m_addr,
   output logic              m_go,
   input  logic              m_rdy,
   input  logic [31:0]       m_data,
   output logic              s_wr,
   output logic [1:0]        s_sel,
   output logic [7:0]        s_wdata,
   input  logic              s_rdy,
   input  logic [7:0]        s_rdata,
   output logic              buf_we,
   output logic [SIZE_W-1:0] buf_addr,
   output logic [31:0]       buf_wdata,
   output logic [3:0]        buf_be,
   output logic              busy,
   output logic              done,
   output logic              err
);
   localparam int DLY_CYC  = DLY_MS * CLK_KHZ;
   localparam int PWR_CYC  = PWR_TMO_MS * CLK_KHZ;
   localparam int MAIN_CYC = MAIN_TMO_MS * CLK_KHZ;
   localparam int SEC_CYC  = SEC_TMO_MS * CLK_KHZ;
   localparam int MAX_CYC  = (MAIN_CYC > PWR_CYC) ? MAIN_CYC : PWR_CYC;
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 9 || ADDR_W > 16)
         $error("ADDR_W must lie in 9..16 for the two-byte secondary address");
      if (SIZE_W < 3)
         $error("SIZE_W too small");
      if (CLK_KHZ < 1 || DLY_MS < 1)
         $error("clock and delay parameters must be positive");
      if (SEC_CYC > MAX_CYC)
         $error("secondary timeout must not exceed the counter range");
   endgenerate

   efr_state_e    st;
   logic          sec_q, skip_q, fail_q;
   logic          accept, reject, empty, m_hit, s_hit;
   logic          tmr_load, tmr_exp;
   logic [CNT_W-1:0] tmr_val;
   logic [ADDR_W-1:0] cur_addr;
   logic [SIZE_W-1:0] offset;
   logic          last;

   assign empty  = (req_size == '0);
   assign reject = !req_sec && (req_addr[1:0] != 2'b00 || req_size[1:0] != 2'b00);
   assign accept = (st == ST_IDLE) && req_valid && !empty && !reject;
   assign m_hit  = (st == ST_M_POLL) && !m_go && m_rdy;
   assign s_hit  = (st == ST_S_POLL) && !s_wr && s_rdy;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (accept) begin
         tmr_load = 1'b1; tmr_val = CNT_W'(PWR_CYC);
      end else if (st == ST_EN_PS || st == ST_DIS_ISO) begin
         tmr_load = 1'b1; tmr_val = CNT_W'(DLY_CYC);
      end else if (st == ST_M_GO) begin
         tmr_load = 1'b1; tmr_val = CNT_W'(MAIN_CYC);
      end else if (st == ST_S_MODE) begin
         tmr_load = 1'b1; tmr_val = CNT_W'(SEC_CYC);
      end
   end

   efr_timer #(.W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
   );

   efr_cursor #(.AW(ADDR_W), .SW(SIZE_W)) u_cur (
      .clk(clk), .rst_n(rst_n), .load(accept), .ld_addr(req_addr), .ld_size(req_size),
      .wide(!sec_q), .step(m_hit || s_hit), .cur_addr(cur_addr), .offset(offset), .last(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         sec_q <= 1'b0; skip_q <= 1'b0; fail_q <= 1'b0;
         pwr_act_req <= 1'b0;
         wmask_ovr <= 1'b0; psw_first <= 1'b0; psw_second <= 1'b0;
         iso_en <= 1'b1; burst_en <= 1'b0;
         m_addr <= '0; m_go <= 1'b0;
         s_wr <= 1'b0; s_sel <= SEL_CTRL; s_wdata <= '0;
         buf_we <= 1'b0; buf_addr <= '0; buf_wdata <= '0; buf_be <= '0;
         busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      end else begin
         m_go   <= 1'b0;
         s_wr   <= 1'b0;
         buf_we <= 1'b0;
         done   <= 1'b0;
         err    <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               if (empty)       done <= 1'b1;
               else if (reject) err  <= 1'b1;
               else begin
                  st <= ST_PWR_ON;
                  sec_q <= req_sec; skip_q <= no_sw_patch; fail_q <= 1'b0;
                  busy <= 1'b1; pwr_act_req <= 1'b1;
               end
            end
            ST_PWR_ON:
               if (pwr_state == ACT_CODE) st <= sec_q ? ST_S_CTRL : ST_EN_WM;
               else if (tmr_exp) begin fail_q <= 1'b1; st <= ST_PWR_OFF; end
            ST_EN_WM: begin
               wmask_ovr <= 1'b1;
               st <= skip_q ? ST_EN_BURST : ST_EN_PS;
            end
            ST_EN_PS:   begin psw_first <= 1'b1; st <= ST_EN_WAIT; end
            ST_EN_WAIT: if (tmr_exp) st <= ST_EN_PB;
            ST_EN_PB:   begin psw_second <= 1'b1; iso_en <= 1'b0; st <= ST_EN_BURST; end
            ST_EN_BURST: begin burst_en <= 1'b1; st <= ST_M_GO; end
            ST_M_GO: begin m_go <= 1'b1; m_addr <= cur_addr; st <= ST_M_POLL; end
            ST_M_POLL:
               if (m_hit) begin
                  buf_we <= 1'b1; buf_addr <= offset; buf_wdata <= m_data; buf_be <= 4'hF;
                  if (last) st <= skip_q ? ST_DIS_WM : ST_DIS_ISO;
                  else      st <= ST_M_GO;
               end else if (!m_go && tmr_exp) begin
                  fail_q <= 1'b1;
                  st <= skip_q ? ST_DIS_WM : ST_DIS_ISO;
               end
            ST_DIS_ISO:  begin iso_en <= 1'b1; psw_second <= 1'b0; st <= ST_DIS_WAIT; end
            ST_DIS_WAIT: if (tmr_exp) st <= ST_DIS_PS;
            ST_DIS_PS:   begin psw_first <= 1'b0; st <= ST_DIS_WM; end
            ST_DIS_WM:   begin wmask_ovr <= 1'b0; burst_en <= 1'b0; st <= ST_PWR_OFF; end
            ST_S_CTRL: begin s_wr <= 1'b1; s_sel <= SEL_CTRL; s_wdata <= SEC_CTRL_VAL; st <= ST_S_LO; end
            ST_S_LO:   begin s_wr <= 1'b1; s_sel <= SEL_LO; s_wdata <= cur_addr[7:0]; st <= ST_S_HI; end
            ST_S_HI:   begin
               s_wr <= 1'b1; s_sel <= SEL_HI; s_wdata <= 8'(cur_addr >> 8); st <= ST_S_MODE;
            end
            ST_S_MODE: begin s_wr <= 1'b1; s_sel <= SEL_MODE; s_wdata <= 8'h00; st <= ST_S_POLL; end
            ST_S_POLL:
               if (s_hit) begin
                  buf_we <= 1'b1; buf_addr <= offset; buf_wdata <= {24'h0, s_rdata}; buf_be <= 4'h1;
                  st <= last ? ST_PWR_OFF : ST_S_CTRL;
               end else if (!s_wr && tmr_exp) begin
                  fail_q <= 1'b1; st <= ST_PWR_OFF;
               end
            ST_PWR_OFF: begin
               pwr_act_req <= 1'b0; busy <= 1'b0;
               done <= !fail_q; err <= fail_q;
               st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/efr_rd_seq_chk.sv
module efr_rd_seq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          pwr_act_req,
   input logic          m_go,
   input logic          s_wr,
   input logic [AW-1:0] m_addr,
   input logic          wmask_ovr,
   input logic          burst_en,
   input logic          psw_first,
   input logic          psw_second,
   input logic          no_sw_patch,
   input logic          buf_we,
   input logic [3:0]    buf_be
);
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   p_err_pulse_r12:  assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);
   p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n) !(done && err));
   p_strobe_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (m_go || s_wr) |-> pwr_act_req);
   p_go_after_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_go |-> (burst_en && wmask_ovr));
   p_switch_nesting_r6: assert property (@(posedge clk) disable iff (!rst_n)
      psw_second |-> psw_first);
   p_word_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      m_go |-> (m_addr[1:0] == 2'b00));
   p_lane_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (buf_be == 4'hF || buf_be == 4'h1));
   p_skip_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && no_sw_patch && $past(busy) && $past(no_sw_patch)) |-> $stable(psw_first));
endmodule

bind efuse_rd_seq efr_rd_seq_chk #(.AW(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
   .pwr_act_req(pwr_act_req), .m_go(m_go), .s_wr(s_wr), .m_addr(m_addr),
   .wmask_ovr(wmask_ovr), .burst_en(burst_en), .psw_first(psw_first),
   .psw_second(psw_second), .no_sw_patch(no_sw_patch), .buf_we(buf_we), .buf_be(buf_be)
);

// File: tb/sim_efuse_rd_seq.sv
module sim_efuse_rd_seq;
   localparam int CLK_PER = 10;
   localparam int KHZ     = 10;
   localparam int DLY     = KHZ;
   localparam logic [2:0] ACT = 3'd4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_sec = 1'b0, no_sw_patch = 1'b0;
   logic [15:0] req_addr = '0;
   logic [11:0] req_size = '0;
   logic pwr_act_req, wmask_ovr, psw_first, psw_second, iso_en, burst_en;
   logic [2:0] pwr_state = 3'd0;
   logic [15:0] m_addr;
   logic m_go, m_rdy = 1'b1, s_wr, s_rdy = 1'b1;
   logic [31:0] m_data = '0;
   logic [1:0] s_sel;
   logic [7:0] s_wdata, s_rdata = '0;
   logic buf_we;
   logic [11:0] buf_addr;
   logic [31:0] buf_wdata;
   logic [3:0] buf_be;
   logic busy, done, err;

   always #(CLK_PER/2) clk = ~clk;

   efuse_rd_seq #(.ADDR_W(16), .SIZE_W(12), .CLK_KHZ(KHZ), .ACT_CODE(ACT)) u0 (.*);

   int n_chk = 0, n_bad = 0;
   bit pwr_stuck = 0, main_stuck = 0, sec_stuck = 0;

   function automatic logic [7:0] mbyte(input logic [15:0] a);
      return a[7:0] ^ 8'h5A ^ {a[10:8], 5'b0};
   endfunction
   function automatic logic [7:0] sbyte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   // power model
   int pcnt = 0;
   always @(posedge clk) begin
      if (pwr_act_req && !pwr_stuck) begin
         if (pcnt == 3) pwr_state <= ACT; else pcnt <= pcnt + 1;
      end else begin
         pcnt <= 0;
         pwr_state <= 3'd0;
      end
   end
   // primary macro model
   int mlat = 0;
   logic [15:0] ma = '0;
   always @(posedge clk) begin
      if (m_go) begin m_rdy <= 1'b0; mlat <= 3; ma <= m_addr; end
      else if (mlat > 1) mlat <= mlat - 1;
      else if (mlat == 1) begin
         mlat <= 0;
         if (!main_stuck) begin
            m_rdy <= 1'b1;
            m_data <= {mbyte(ma + 16'd3), mbyte(ma + 16'd2), mbyte(ma + 16'd1), mbyte(ma)};
         end
      end
   end
   // secondary macro model
   int slat = 0;
   logic [7:0] s_lo = '0, s_hi = '0;
   always @(posedge clk) begin
      if (s_wr) begin
         if (s_sel == 2'd1) s_lo <= s_wdata;
         if (s_sel == 2'd2) s_hi <= s_wdata;
         if (s_sel == 2'd3) begin s_rdy <= 1'b0; slat <= 2; end
      end else if (slat > 1) slat <= slat - 1;
      else if (slat == 1) begin
         slat <= 0;
         if (!sec_stuck) begin s_rdy <= 1'b1; s_rdata <= sbyte({s_hi, s_lo}); end
      end
   end

   // monitor
   int cyc = 0;
   logic [7:0] bmem [0:255];
   int r_wm, f_wm, r_ps, f_ps, r_pb, f_pb, r_iso, f_iso, r_bu, f_bu, r_act, g_first, g_last;
   int n_go, n_swr, n_prise, n_done, n_err, n_swevt, t_end;
   logic [1:0] wsel [0:63];
   logic [7:0] wdat [0:63];
   logic p_wm, p_ps, p_pb, p_iso, p_bu, p_pa, p_act;

   task automatic clear_log();
      r_wm = 0; f_wm = 0; r_ps = 0; f_ps = 0; r_pb = 0; f_pb = 0; r_iso = 0; f_iso = 0;
      r_bu = 0; f_bu = 0; r_act = 0; g_first = 0; g_last = 0;
      n_go = 0; n_swr = 0; n_prise = 0; n_done = 0; n_err = 0; n_swevt = 0; t_end = 0;
      for (int i = 0; i < 256; i++) bmem[i] = 8'hEE;
   endtask

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (wmask_ovr && !p_wm) r_wm = cyc;
         if (!wmask_ovr && p_wm) f_wm = cyc;
         if (psw_first && !p_ps) r_ps = cyc;
         if (!psw_first && p_ps) f_ps = cyc;
         if (psw_second && !p_pb) r_pb = cyc;
         if (!psw_second && p_pb) f_pb = cyc;
         if (iso_en && !p_iso) r_iso = cyc;
         if (!iso_en && p_iso) f_iso = cyc;
         if (burst_en && !p_bu) r_bu = cyc;
         if (!burst_en && p_bu) f_bu = cyc;
         if ((psw_first != p_ps) || (psw_second != p_pb) || (iso_en != p_iso)) n_swevt++;
         if (pwr_act_req && !p_pa) n_prise++;
         if ((pwr_state == ACT) && !p_act) r_act = cyc;
         if (m_go) begin if (n_go == 0) g_first = cyc; g_last = cyc; n_go++; end
         if (s_wr) begin
            if (n_swr < 64) begin wsel[n_swr] = s_sel; wdat[n_swr] = s_wdata; end
            n_swr++;
         end
         if (buf_we)
            for (int i = 0; i < 4; i++)
               if (buf_be[i]) bmem[(int'(buf_addr) + i) % 256] = buf_wdata[8*i +: 8];
         if (done) begin n_done++; t_end = cyc; end
         if (err)  begin n_err++;  t_end = cyc; end
      end
      p_wm = wmask_ovr; p_ps = psw_first; p_pb = psw_second; p_iso = iso_en;
      p_bu = burst_en; p_pa = pwr_act_req; p_act = (pwr_state == ACT);
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [15:0] a, input logic [11:0] n, input bit sec);
      @(negedge clk);
      req_addr = a; req_size = n; req_sec = sec; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_end();
      while (n_done + n_err == 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !err, "R12 idle after reset", {busy, done, err}, 0);
      chk(!pwr_act_req && iso_en && !wmask_ovr && !burst_en && !psw_first && !psw_second,
          "R3 reset controls", {pwr_act_req, iso_en, wmask_ovr, burst_en, psw_first, psw_second}, 6'b010000);
   endtask

   task automatic t_reject();
      clear_log();
      issue(16'h0012, 12'd8, 1'b0);
      chk(err && !busy, "R1 misaligned address refused next cycle", {err, busy}, 2'b10);
      repeat (4) @(negedge clk);
      issue(16'h0010, 12'd6, 1'b0);
      repeat (4) @(negedge clk);
      chk(n_err == 2, "R1 two refusals", n_err, 2);
      chk(n_prise == 0 && n_go == 0, "R1 no power or strobe", n_prise + n_go, 0);
   endtask

   task automatic t_zero();
      clear_log();
      issue(16'h0020, 12'd0, 1'b0);
      chk(done && !busy, "R2 zero size completes next cycle", {done, busy}, 2'b10);
      issue(16'h0003, 12'd0, 1'b1);
      repeat (4) @(negedge clk);
      chk(n_done == 2 && n_prise == 0 && n_go == 0 && n_swr == 0, "R2 no fuse traffic",
          n_prise + n_go + n_swr, 0);
   endtask

   task automatic t_main(input logic [15:0] a, input int n, input bit skip);
      clear_log();
      no_sw_patch = skip;
      issue(a, 12'(n), 1'b0);
      chk(busy, "R12 busy after accept", busy, 1);
      wait_end();
      chk(n_done == 1 && n_err == 0, "R8 primary read completes", n_err, 0);
      chk(n_go == n / 4, "R8 one strobe per word", n_go, n / 4);
      for (int i = 0; i < n; i++)
         chk(bmem[i] == mbyte(a + 16'(i)), "R8 little-endian byte", bmem[i], mbyte(a + 16'(i)));
      chk(r_act > 0 && r_wm > r_act, "R3 controls wait for active", r_wm, r_act);
      chk(!pwr_act_req && iso_en && !wmask_ovr && !burst_en, "R3 idle after access",
          {pwr_act_req, iso_en, wmask_ovr, burst_en}, 4'b0100);
      chk(t_end > f_wm, "R3 power request dropped before pulse", t_end, f_wm);
      chk(g_first > r_bu && r_bu > r_wm, "R5 burst then first strobe", g_first, r_bu);
      chk(f_bu == f_wm && f_wm > g_last, "R6 mask and burst fall together last", f_bu, f_wm);
      if (!skip) begin
         chk(r_ps > r_wm, "R5 first switch after mask", r_ps, r_wm);
         chk(r_pb - r_ps >= DLY, "R5 settle delay", r_pb - r_ps, DLY);
         chk(f_iso == r_pb && r_bu > r_pb, "R5 isolation drop with second switch", f_iso, r_pb);
         chk(r_iso == f_pb && f_pb > g_last, "R6 isolation back with second switch off", r_iso, f_pb);
         chk(f_ps - f_pb >= DLY, "R6 release delay", f_ps - f_pb, DLY);
         chk(f_wm > f_ps, "R6 mask released after first switch", f_wm, f_ps);
      end else begin
         chk(n_swevt == 0, "R7 switches untouched when strap set", n_swevt, 0);
         chk(r_wm > 0 && r_bu > 0, "R7 mask and burst still run", r_bu, 1);
      end
      no_sw_patch = 1'b0;
   endtask

   task automatic t_sec(input logic [15:0] a, input int n);
      clear_log();
      issue(a, 12'(n), 1'b1);
      wait_end();
      chk(n_done == 1 && n_err == 0, "R10 secondary completes", n_err, 0);
      chk(n_swr == 4 * n, "R10 four writes per byte", n_swr, 4 * n);
      chk(n_go == 0 && r_wm == 0, "R10 primary path idle", n_go + r_wm, 0);
      for (int b = 0; b < n; b++) begin
         logic [15:0] ab = a + 16'(b);
         chk(wsel[4*b] == 2'd0 && wdat[4*b] == 8'h40, "R10 control write", wdat[4*b], 8'h40);
         chk(wsel[4*b+1] == 2'd1 && wdat[4*b+1] == ab[7:0], "R10 low address", wdat[4*b+1], ab[7:0]);
         chk(wsel[4*b+2] == 2'd2 && wdat[4*b+2] == ab[15:8], "R10 high address", wdat[4*b+2], ab[15:8]);
         chk(wsel[4*b+3] == 2'd3 && wdat[4*b+3] == 8'h00, "R10 mode write", wdat[4*b+3], 0);
         chk(bmem[b] == sbyte(ab), "R10 byte stored", bmem[b], sbyte(ab));
      end
      chk(bmem[n] == 8'hEE, "R10 single lane only", bmem[n], 8'hEE);
   endtask

   task automatic t_pwr_timeout();
      clear_log();
      pwr_stuck = 1;
      issue(16'h0040, 12'd4, 1'b0);
      wait_end();
      chk(n_err == 1 && n_done == 0, "R4 power wait expires with error", n_err, 1);
      chk(n_go == 0 && r_wm == 0, "R4 no fuse activity", n_go, 0);
      chk(!pwr_act_req, "R4 power request released", pwr_act_req, 0);
      pwr_stuck = 0;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_main_timeout();
      clear_log();
      main_stuck = 1;
      issue(16'h0080, 12'd8, 1'b0);
      wait_end();
      chk(n_err == 1 && n_done == 0, "R9 primary poll expires with error", n_err, 1);
      chk(t_end - g_first >= 1000 * KHZ, "R9 full wait before error", t_end - g_first, 1000 * KHZ);
      chk(n_go == 1, "R9 no further words", n_go, 1);
      chk(iso_en && !psw_first && !psw_second && !wmask_ovr && !burst_en && !pwr_act_req,
          "R9 torn down", {iso_en, psw_first, psw_second, wmask_ovr, burst_en, pwr_act_req}, 6'b100000);
      main_stuck = 0;
      clear_log();
      issue(16'h0080, 12'd4, 1'b0);
      wait_end();
      chk(n_done == 1 && bmem[0] == mbyte(16'h0080), "R9 recovers after error", bmem[0], mbyte(16'h0080));
   endtask

   task automatic t_sec_timeout();
      clear_log();
      sec_stuck = 1;
      issue(16'h0300, 12'd2, 1'b1);
      wait_end();
      chk(n_err == 1 && n_done == 0, "R11 secondary poll expires with error", n_err, 1);
      chk(n_swr == 4, "R11 stopped after first byte", n_swr, 4);
      chk(!pwr_act_req && !busy, "R11 idle after error", {pwr_act_req, busy}, 0);
      sec_stuck = 0;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_busy_ignore();
      clear_log();
      issue(16'h0100, 12'd8, 1'b0);
      repeat (5) @(negedge clk);
      req_addr = 16'h0003; req_size = 12'd4; req_sec = 1'b0; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_end();
      repeat (5) @(negedge clk);
      chk(n_err == 0 && n_done == 1, "R12 request during busy ignored", n_err, 0);
      chk(n_go == 2 && bmem[7] == mbyte(16'h0107), "R12 original access intact", n_go, 2);
   endtask

   initial begin
      clear_log();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reject();
      t_zero();
      t_main(16'h0010, 16, 1'b0);
      t_main(16'h0200, 8, 1'b1);
      t_sec(16'h01FE, 3);
      t_pwr_timeout();
      t_sec_timeout();
      t_busy_ignore();
      t_main_timeout();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PER * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule